// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Controller

This block controls the operand bypass paths and the load-use interlock of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the register fields of the instructions in decode, execute and memory, along with their valid, write-enable, load and store flags. From these it decides whether the pipeline front must hold for one cycle and whether execute must receive a bubble. It also decides which source feeds each execute operand and the store-data input in the memory stage.

The operand selects are registered. They are computed while the consumer is still in decode and are presented during the cycle in which that consumer sits in execute. At that time, a producer that was in execute has reached memory, and a producer that was in memory has reached write-back. The store-data select is computed the same way from the store in execute and is presented while the store is in memory. The register file writes early in a cycle and reads late, so a producer in write-back needs no bypass for a consumer in decode. The stall and bubble outputs are combinational because they must act in the cycle the hazard is seen.

Top module: `hazard_fwd_ctl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fwd_a_sel`, `fwd_b_sel` and `st_data_sel` are all 0. A matching producer present during reset does not change them.
- R2: If a decode source that is read matches the destination of a valid, writing instruction in execute, the select for that operand is 01 (memory-stage bypass) in the next cycle.
- R3: If a decode source that is read matches the destination of a valid, writing instruction in memory and no execute producer matches, the select is 10 (write-back bypass) in the next cycle.
- R4: If both the execute and memory producers write the same source register, the execute producer (the younger one) wins and the select is 01.
- R5: Operand A (first source) and operand B (second source) are resolved independently. One consumer can receive 10 on one operand and 01 on the other.
- R6: Register 0 never produces a bypass or a stall, even when a producer names it as its destination.
- R7: No bypass or stall arises from a producer with valid or write-enable low, or from a source field the consumer does not read.
- R8: If a valid load in execute writes a register that the decode instruction reads as an ALU operand or as a store base, `stall_f`, `stall_d` and `bubble_x` are 1 in that same cycle. Both selects are 00 in the next cycle for the bubble. Once the load reaches memory, the held consumer gets 10 on that operand.
- R9: A store in decode whose only dependence on a load in execute is its data register (second source) raises no stall, and its operand B select is not 01 in the next cycle. The next cycle, when the store is in execute and its data register matches the writing instruction in memory, `st_data_sel` is 1 in the following cycle. Otherwise `st_data_sel` is 0.
- R10: A store in decode whose base register (first source) matches the destination of a load in execute stalls exactly as in R8.
- R11: A producer that is three instructions ahead is in write-back while the consumer is in decode. It causes no bypass, and the select is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_valid | input | 1 | Decode slot holds a real instruction |
| d_rs1 | input | 5 | Decode first source register |
| d_rs2 | input | 5 | Decode second source register |
| d_use_rs1 | input | 1 | Decode instruction reads its first source |
| d_use_rs2 | input | 1 | Decode instruction reads its second source |
| d_is_store | input | 1 | Decode instruction is a store (second source is store data) |
| x_valid | input | 1 | Execute slot holds a real instruction |
| x_wen | input | 1 | Execute instruction writes a register |
| x_rd | input | 5 | Execute destination register |
| x_is_load | input | 1 | Execute instruction is a load |
| x_is_store | input | 1 | Execute instruction is a store |
| x_rs2 | input | 5 | Execute second source (store data register) |
| m_valid | input | 1 | Memory slot holds a real instruction |
| m_wen | input | 1 | Memory instruction writes a register |
| m_rd | input | 5 | Memory destination register |
| stall_f | output | 1 | Hold the fetch stage |
| stall_d | output | 1 | Hold the decode stage |
| bubble_x | output | 1 | Load an empty slot into execute |
| fwd_a_sel | output | 2 | Execute operand A source: 00 register file, 01 memory bypass, 10 write-back bypass |
| fwd_b_sel | output | 2 | Execute operand B source, same encoding |
| st_data_sel | output | 1 | Memory store data: 0 pipelined value, 1 write-back bypass |

## Verification
The bypass logic is driven with a single match in execute and a single match in memory. These separate the two nonzero select codes and show that each reaches the correct operand. A double match on one register and a split match across both operands separate the priority rule from independent per-operand resolution. Register 0 targets, invalid or non-writing producers and unread source fields show that matching is gated. A load ahead of an ALU consumer, of a store base and of store data separates the stall cases from the stall-free store-data path, and a three-ahead producer confirms that no bypass is issued across write-back.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int SELW = 2;
  localparam int NSRC = 2;

  typedef enum logic [SELW-1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } opsel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          use_src,
  input  logic [AW-1:0] src,
  input  logic          near_ok,
  input  logic [AW-1:0] near_rd,
  input  logic          far_ok,
  input  logic [AW-1:0] far_rd,
  output logic [SELW-1:0] sel
);
  logic live, near_hit, far_hit;

  always_comb begin
    live     = use_src && (src != '0);
    near_hit = live && near_ok && (near_rd == src);
    far_hit  = live && far_ok && (far_rd == src);
    if (near_hit)     sel = SEL_MEM;
    else if (far_hit) sel = SEL_WB;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int AW = 5
) (
  input  logic          d_valid,
  input  logic          d_use_rs1,
  input  logic [AW-1:0] d_rs1,
  input  logic          d_use_rs2,
  input  logic [AW-1:0] d_rs2,
  input  logic          d_is_store,
  input  logic          x_valid,
  input  logic          x_wen,
  input  logic          x_is_load,
  input  logic [AW-1:0] x_rd,
  output logic          hold
);
  logic ld_live, hit1, hit2;

  always_comb begin
    ld_live = x_valid && x_wen && x_is_load && (x_rd != '0) && d_valid;
    hit1    = d_use_rs1 && (d_rs1 == x_rd);
    // store data is consumed in memory stage, so it never forces a hold
    hit2    = d_use_rs2 && !d_is_store && (d_rs2 == x_rd);
    hold    = ld_live && (hit1 || hit2);
  end
endmodule

// File: rtl/hz_stdata.sv
module hz_stdata #(
  parameter int AW = 5
) (
  input  logic          x_valid,
  input  logic          x_is_store,
  input  logic [AW-1:0] x_rs2,
  input  logic          m_valid,
  input  logic          m_wen,
  input  logic [AW-1:0] m_rd,
  output logic          byp
);
  always_comb begin
    byp = x_valid && x_is_store && (x_rs2 != '0) &&
          m_valid && m_wen && (m_rd == x_rs2);
  end
endmodule

// File: rtl/hazard_fwd_ctl.sv
module hazard_fwd_ctl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          d_valid,
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic          d_use_rs1,
  input  logic          d_use_rs2,
  input  logic          d_is_store,
  input  logic          x_valid,
  input  logic          x_wen,
  input  logic [AW-1:0] x_rd,
  input  logic          x_is_load,
  input  logic          x_is_store,
  input  logic [AW-1:0] x_rs2,
  input  logic          m_valid,
  input  logic          m_wen,
  input  logic [AW-1:0] m_rd,
  output logic          stall_f,
  output logic          stall_d,
  output logic          bubble_x,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          st_data_sel
);
  logic [NSRC-1:0]          src_use;
  logic [NSRC-1:0][AW-1:0]  src_reg;
  logic [NSRC-1:0]          near_ok;
  logic [NSRC-1:0][SELW-1:0] nxt_sel;
  logic                     hold;
  logic                     st_nxt;
  logic                     x_prod, m_prod;

  assign x_prod     = x_valid && x_wen;
  assign m_prod     = m_valid && m_wen;
  assign src_use[0] = d_valid && d_use_rs1;
  assign src_use[1] = d_valid && d_use_rs2;
  assign src_reg[0] = d_rs1;
  assign src_reg[1] = d_rs2;
  assign near_ok[0] = x_prod;
  // load data is not ready in memory stage for a store's data operand;
  // the store-data bypass in memory covers that case instead
  assign near_ok[1] = x_prod && !(d_is_store && x_is_load);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_fwd_pick #(.AW(AW)) u_pick (
      .use_src (src_use[g]),
      .src     (src_reg[g]),
      .near_ok (near_ok[g]),
      .near_rd (x_rd),
      .far_ok  (m_prod),
      .far_rd  (m_rd),
      .sel     (nxt_sel[g])
    );
  end

  hz_loaduse #(.AW(AW)) u_lu (
    .d_valid    (d_valid),
    .d_use_rs1  (d_use_rs1),
    .d_rs1      (d_rs1),
    .d_use_rs2  (d_use_rs2),
    .d_rs2      (d_rs2),
    .d_is_store (d_is_store),
    .x_valid    (x_valid),
    .x_wen      (x_wen),
    .x_is_load  (x_is_load),
    .x_rd       (x_rd),
    .hold       (hold)
  );

  hz_stdata #(.AW(AW)) u_st (
    .x_valid    (x_valid),
    .x_is_store (x_is_store),
    .x_rs2      (x_rs2),
    .m_valid    (m_valid),
    .m_wen      (m_wen),
    .m_rd       (m_rd),
    .byp        (st_nxt)
  );

  assign stall_f  = hold;
  assign stall_d  = hold;
  assign bubble_x = hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_a_sel   <= SEL_RF;
      fwd_b_sel   <= SEL_RF;
      st_data_sel <= 1'b0;
    end else begin
      fwd_a_sel   <= hold ? SEL_RF : nxt_sel[0];
      fwd_b_sel   <= hold ? SEL_RF : nxt_sel[1];
      st_data_sel <= st_nxt;
    end
  end

  // R8: a bubble entering execute never carries a bypass
  p_bubble_clean_r8: assert property (@(posedge clk) disable iff (rst)
    stall_d |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

  // R8/R10: a load feeding an execute operand of decode must hold the front
  p_loaduse_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (d_valid && d_use_rs1 && x_valid && x_wen && x_is_load &&
     d_rs1 != '0 && d_rs1 == x_rd) |-> (stall_f && stall_d && bubble_x));

  // R9: store data alone never holds the pipeline
  p_store_nohold_r9: assert property (@(posedge clk) disable iff (rst)
    (d_is_store && !d_use_rs1) |-> !stall_d);

  // R6: register 0 on operand A never bypasses
  p_zero_src_r6: assert property (@(posedge clk) disable iff (rst)
    (d_rs1 == '0) |=> (fwd_a_sel == 2'b00));

  // R2: encoding 11 never appears
  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

  // R7: no memory-stage producer, no store-data bypass
  p_stdata_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !(m_valid && m_wen) |=> !st_data_sel);
endmodule

// File: tb/hazard_fwd_ctl_test.sv
module hazard_fwd_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic d_valid, d_use_rs1, d_use_rs2, d_is_store;
  logic [4:0] d_rs1, d_rs2, x_rd, x_rs2, m_rd;
  logic x_valid, x_wen, x_is_load, x_is_store, m_valid, m_wen;
  logic stall_f, stall_d, bubble_x, st_data_sel;
  logic [1:0] fwd_a_sel, fwd_b_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] qa[$];
  logic [1:0] qb[$];
  logic       qs[$];
  string      qt[$];

  always #2 clk = ~clk;

  hazard_fwd_ctl uut (
    .clk(clk), .rst(rst),
    .d_valid(d_valid), .d_rs1(d_rs1), .d_rs2(d_rs2),
    .d_use_rs1(d_use_rs1), .d_use_rs2(d_use_rs2), .d_is_store(d_is_store),
    .x_valid(x_valid), .x_wen(x_wen), .x_rd(x_rd), .x_is_load(x_is_load),
    .x_is_store(x_is_store), .x_rs2(x_rs2),
    .m_valid(m_valid), .m_wen(m_wen), .m_rd(m_rd),
    .stall_f(stall_f), .stall_d(stall_d), .bubble_x(bubble_x),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .st_data_sel(st_data_sel)
  );

  task automatic drive(
    input logic dv, input logic [4:0] r1, input logic u1,
    input logic [4:0] r2, input logic u2, input logic dst,
    input logic xv, input logic xw, input logic [4:0] xd,
    input logic xl, input logic xs, input logic [4:0] xr2,
    input logic mv, input logic mw, input logic [4:0] md);
    d_valid = dv; d_rs1 = r1; d_use_rs1 = u1; d_rs2 = r2; d_use_rs2 = u2;
    d_is_store = dst;
    x_valid = xv; x_wen = xw; x_rd = xd; x_is_load = xl; x_is_store = xs;
    x_rs2 = xr2;
    m_valid = mv; m_wen = mw; m_rd = md;
  endtask

  // drive one cycle: check stall now, queue the selects expected after the edge
  task automatic step(
    input logic dv, input logic [4:0] r1, input logic u1,
    input logic [4:0] r2, input logic u2, input logic dst,
    input logic xv, input logic xw, input logic [4:0] xd,
    input logic xl, input logic xs, input logic [4:0] xr2,
    input logic mv, input logic mw, input logic [4:0] md,
    input logic e_stall, input logic [1:0] ea, input logic [1:0] eb,
    input logic es, input string tag);
    @(negedge clk);
    drive(dv, r1, u1, r2, u2, dst, xv, xw, xd, xl, xs, xr2, mv, mw, md);
    #1;
    n_cmp++;
    if (stall_f !== e_stall || stall_d !== e_stall || bubble_x !== e_stall) begin
      n_bad++;
      $display("FAIL %s stall: got f%b d%b x%b expected %b",
               tag, stall_f, stall_d, bubble_x, e_stall);
    end
    qa.push_back(ea); qb.push_back(eb); qs.push_back(es); qt.push_back(tag);
  endtask

  // monitor: compare registered selects one edge after the stimulus
  always @(posedge clk) begin
    #1;
    if (qa.size() > 0) begin
      logic [1:0] ea, eb;
      logic es;
      string t;
      ea = qa.pop_front(); eb = qb.pop_front(); es = qs.pop_front();
      t = qt.pop_front();
      n_cmp++;
      if (fwd_a_sel !== ea || fwd_b_sel !== eb || st_data_sel !== es) begin
        n_bad++;
        $display("FAIL %s sel: got a=%b b=%b st=%b expected a=%b b=%b st=%b",
                 t, fwd_a_sel, fwd_b_sel, st_data_sel, ea, eb, es);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(1, 5'd5, 1, 5'd6, 1, 0, 1, 1, 5'd5, 0, 1, 5'd6, 1, 1, 5'd6);
    repeat (3) @(negedge clk);
    n_cmp++;  // R1: matching producers present while in reset
    if (fwd_a_sel !== 2'b00 || fwd_b_sel !== 2'b00 || st_data_sel !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got a=%b b=%b st=%b expected 00 00 0",
               fwd_a_sel, fwd_b_sel, st_data_sel);
    end
    rst = 1'b0;

    // args: D(v,rs1,u1,rs2,u2,st) X(v,w,rd,ld,st,rs2) M(v,w,rd) stall a b st tag
    step(1,5'd5,1,5'd6,1,0, 1,1,5'd5,0,0,5'd0, 1,1,5'd9, 0,2'b01,2'b00,0,"R2");
    step(1,5'd3,1,5'd7,1,0, 1,1,5'd9,0,0,5'd0, 1,1,5'd7, 0,2'b00,2'b10,0,"R3");
    step(1,5'd8,1,5'd1,0,0, 1,1,5'd8,0,0,5'd0, 1,1,5'd8, 0,2'b01,2'b00,0,"R4");
    step(1,5'd4,1,5'd11,1,0,1,1,5'd11,0,0,5'd0,1,1,5'd4, 0,2'b10,2'b01,0,"R5");
    step(1,5'd0,1,5'd0,1,0, 1,1,5'd0,1,0,5'd0, 1,1,5'd0, 0,2'b00,2'b00,0,"R6");
    step(1,5'd12,1,5'd13,0,0,0,1,5'd12,1,0,5'd0,1,0,5'd12,0,2'b00,2'b00,0,"R7");
    step(1,5'd15,1,5'd13,0,0,1,1,5'd13,0,0,5'd0,1,0,5'd15,0,2'b00,2'b00,0,"R7b");
    step(0,5'd16,1,5'd16,1,0,1,1,5'd16,1,0,5'd0,1,1,5'd16,0,2'b00,2'b00,0,"R7c");
    // R11: producer of x14 already in write-back, unrelated work in X and M
    step(1,5'd14,1,5'd14,1,0,1,1,5'd2,0,0,5'd0, 1,1,5'd3, 0,2'b00,2'b00,0,"R11");
    // R8: load x20 in X, consumer reads x20 on operand A
    step(1,5'd20,1,5'd1,1,0, 1,1,5'd20,1,0,5'd0, 1,1,5'd1, 1,2'b00,2'b00,0,"R8 hold");
    step(1,5'd20,1,5'd1,1,0, 0,0,5'd0,0,0,5'd0,  1,1,5'd20,0,2'b10,2'b00,0,"R8 after");
    step(1,5'd2,1,5'd21,1,0, 1,1,5'd21,1,0,5'd0, 0,0,5'd0, 1,2'b00,2'b00,0,"R8 rs2");
    // R9: load x22 then store of x22 with independent base
    step(1,5'd2,1,5'd22,1,1, 1,1,5'd22,1,0,5'd0, 0,0,5'd0, 0,2'b00,2'b00,0,"R9 nohold");
    step(1,5'd3,1,5'd4,1,0,  1,0,5'd0,0,1,5'd22, 1,1,5'd22,0,2'b00,2'b00,1,"R9 bypass");
    step(1,5'd3,1,5'd4,1,0,  1,0,5'd0,0,1,5'd9,  1,0,5'd9, 0,2'b00,2'b00,0,"R9 gate");
    step(1,5'd3,1,5'd4,1,0,  1,0,5'd0,0,1,5'd0,  1,1,5'd0, 0,2'b00,2'b00,0,"R9 zero");
    // R10: store base depends on load
    step(1,5'd23,1,5'd1,1,1, 1,1,5'd23,1,0,5'd0, 0,0,5'd0, 1,2'b00,2'b00,0,"R10");

    @(negedge clk);
    drive(0,0,0,0,0,0, 0,0,0,0,0,0, 0,0,0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule